// File: doc/BRIEF.md
# Nibble Serial Result Receiver

This block rebuilds a 32-bit result word that a peripheral sends over a five-wire lane. Each clock, the lane carries one 4-bit nibble and a start flag. A new message starts with the start flag high for one clock, together with the lowest nibble. The next seven clocks carry the higher nibbles in rising order. After a message, the sender keeps repeating it until it has a new value. Framing therefore comes only from the start flag, and the receiver needs no free-running counter shared with the sender.

The receiver keeps its own nibble position. The start flag resets the position, and the position wraps after the last slot, so a repeated message keeps refreshing the assembled word. When the last nibble is accepted, the word becomes visible on `word_o` and `word_valid_o` rises. A start flag lowers the valid bit again. The previous word stays on `word_o` until the new word is complete.

A one-cycle read request returns the word visible at the request edge, with an acknowledge on the following clock. A sender that is disabled drives zero nibbles. One full pass of zero nibbles therefore makes the visible word zero.

Top module: `nrx_result_rx`

## Requirements
- R1: While `rst_ni` is low, `word_o` is 0, `word_valid_o` is 0, `rd_data_o` is 0 and `rd_ack_o` is 0.
- R2: The nibble on a clock where `lane_sof_i` is 1 is placed in bits 3:0, whatever position the receiver was at before.
- R3: The k-th nibble after the start flag (k = 1..7) is placed in bits 4k+3:4k.
- R4: `word_valid_o` is 0 after the edges that take the first seven nibbles of a message. It is 1 after the edge that takes the eighth nibble, and `word_o` then equals the whole message.
- R5: A start flag clears `word_valid_o` on that edge, while `word_o` keeps the previous complete word.
- R6: A start flag that arrives before eight nibbles are complete drops the partial nibbles. The later full message is assembled correctly.
- R7: Once eight nibbles without a start flag follow a complete message, the receiver has wrapped to bits 3:0. If those nibbles repeat the same message, `word_o` and `word_valid_o` are unchanged.
- R8: Eight zero nibbles without a start flag, aligned to a completed pass, make `word_o` equal 0x00000000, and `word_valid_o` stays 1.
- R9: Until the first start flag after reset, `word_o` stays 0 and `word_valid_o` stays 0 for any nibbles on the lane.
- R10: If `rd_req_i` is 1 at an edge, then after that edge `rd_ack_o` is 1 and `rd_data_o` equals the value `word_o` had before that edge. If `rd_req_i` is 0, `rd_ack_o` is 0 and `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_nib_i | input | 4 | Data nibble on the lane |
| lane_sof_i | input | 1 | Start-of-message flag, high for one clock |
| rd_req_i | input | 1 | Read request, one cycle |
| rd_data_o | output | 32 | Word returned by the last read |
| rd_ack_o | output | 1 | Read acknowledge, one cycle after the request |
| word_o | output | 32 | Last complete word |
| word_valid_o | output | 1 | Assembly finished since the last start flag |

## Verification
The stimulus words cover these cases:
- All ones and all zeros.
- A different digit in every nibble, which shows up any slot swap or reversed ordering.
- Single-bit values at the two ends of the word, which show up off-by-one nibble placement.

Further tests cover these cases:
- A repeated pass with no start flag checks that wrapping keeps the word stable.
- A pass of zero nibbles checks that a silent sender clears the word.
- An aborted message followed by a new start flag checks that partial nibbles are dropped.
- Random nibbles before any start flag check that nothing is committed without framing.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
  localparam int unsigned NIB_W_DEF = 4;
  localparam int unsigned NIBS_DEF  = 8;

  function automatic int unsigned pos_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nrx_pos_ctr.sv
module nrx_pos_ctr #(
  parameter int unsigned NIBS  = 8,
  parameter int unsigned POS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  output logic [POS_W-1:0] cur_pos_o,
  output logic             last_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(NIBS - 1);

  logic [POS_W-1:0] pos_q;

  // slot of the nibble accepted this cycle
  assign cur_pos_o = sof_i ? '0 : pos_q;
  assign last_o    = (cur_pos_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (last_o) pos_q <= '0;
    else             pos_q <= cur_pos_o + POS_W'(1);
  end

  assert_sof_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (pos_q == POS_W'(1)));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_i && pos_q == LAST) |=> (pos_q == '0));
endmodule

// File: rtl/nrx_assembler.sv
module nrx_assembler #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NIBS  = 8,
  parameter int unsigned POS_W = 3,
  localparam int unsigned WORD_W = NIB_W * NIBS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [POS_W-1:0]  cur_pos_i,
  output logic [WORD_W-1:0] full_o
);
  logic [WORD_W-1:0] asm_q;

  for (genvar k = 0; k < NIBS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       asm_q[k*NIB_W +: NIB_W] <= '0;
      else if (cur_pos_i == POS_W'(k))   asm_q[k*NIB_W +: NIB_W] <= nib_i;
    end
  end

  // top slot bypasses the register so the word is ready on the last nibble
  assign full_o = {nib_i, asm_q[WORD_W-NIB_W-1:0]};

  assert_first_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_pos_i == '0) |=> (asm_q[NIB_W-1:0] == $past(nib_i)));
endmodule

// File: rtl/nrx_result_rx.sv
module nrx_result_rx
  import nrx_pkg::*;
#(
  parameter int unsigned NIB_W = NIB_W_DEF,
  parameter int unsigned NIBS  = NIBS_DEF,
  localparam int unsigned WORD_W = NIB_W * NIBS,
  localparam int unsigned POS_W  = pos_bits(NIBS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  lane_nib_i,
  input  logic              lane_sof_i,
  input  logic              rd_req_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_ack_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic [POS_W-1:0]  cur_pos;
  logic              pos_last;
  logic [WORD_W-1:0] full_word;
  logic              armed_q, valid_q;
  logic [WORD_W-1:0] word_q, rd_data_q;
  logic              rd_ack_q;
  logic              commit;

  nrx_pos_ctr #(.NIBS(NIBS), .POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni, .sof_i(lane_sof_i), .cur_pos_o(cur_pos), .last_o(pos_last)
  );

  nrx_assembler #(.NIB_W(NIB_W), .NIBS(NIBS), .POS_W(POS_W)) u_asm (
    .clk_i, .rst_ni, .nib_i(lane_nib_i), .cur_pos_i(cur_pos), .full_o(full_word)
  );

  assign commit = pos_last && armed_q && !lane_sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      valid_q   <= 1'b0;
      word_q    <= '0;
      rd_data_q <= '0;
      rd_ack_q  <= 1'b0;
    end else begin
      if (lane_sof_i) armed_q <= 1'b1;
      if (lane_sof_i)  valid_q <= 1'b0;
      else if (commit) valid_q <= 1'b1;
      if (commit) word_q <= full_word;
      rd_ack_q <= rd_req_i;
      if (rd_req_i) rd_data_q <= word_q;
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;
  assign rd_data_o    = rd_data_q;
  assign rd_ack_o     = rd_ack_q;

  assert_sof_clears_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_sof_i |=> !word_valid_o);
  assert_valid_on_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) |-> $past(pos_last));
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (word_o == '0 && !word_valid_o));
  assert_rd_return_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> (rd_ack_o && rd_data_o == $past(word_o)));
  assert_no_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> (!rd_ack_o && $stable(rd_data_o)));
endmodule

// File: tb/sim_nrx_result_rx.sv
module sim_nrx_result_rx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  lane_nib_i = '0;
  logic        lane_sof_i = 1'b0;
  logic        rd_req_i = 1'b0;
  logic [31:0] rd_data_o, word_o;
  logic        rd_ack_o, word_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  nrx_result_rx u0 (
    .clk_i, .rst_ni, .lane_nib_i, .lane_sof_i, .rd_req_i,
    .rd_data_o, .rd_ack_o, .word_o, .word_valid_o
  );

  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678,
    32'h8000_0001, 32'hA5C3_0F96, 32'h0F0F_0F0F
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_nib(input logic s, input logic [3:0] n, input logic r);
    @(negedge clk_i);
    lane_sof_i = s;
    lane_nib_i = n;
    rd_req_i   = r;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    logic [31:0] prev;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 word", word_o, 0);
    chk("R1 valid", 32'(word_valid_o), 0);
    chk("R1 rd_data", rd_data_o, 0);
    chk("R1 ack", 32'(rd_ack_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R9: no framing yet
    for (int i = 0; i < 10; i++) drive_nib(1'b0, 4'(4'hA + i), 1'b0);
    chk("R9 word", word_o, 0);
    chk("R9 valid", 32'(word_valid_o), 0);

    // R2 R3 R4 R5: vector walk
    prev = 32'h0;
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 8; k++) begin
        drive_nib(k == 0, VEC[i][4*k +: 4], 1'b0);
        if (k == 0) begin
          chk("R5 valid cleared", 32'(word_valid_o), 0);
          chk("R5 word held", word_o, prev);
        end
        if (k == 6) chk("R4 valid before last", 32'(word_valid_o), 0);
      end
      chk("R2 R3 word", word_o, VEC[i]);
      chk("R4 valid", 32'(word_valid_o), 1);
      prev = VEC[i];
    end

    // R7: repeated pass, no start flag
    for (int k = 0; k < 8; k++) drive_nib(1'b0, prev[4*k +: 4], 1'b0);
    chk("R7 word", word_o, prev);
    chk("R7 valid", 32'(word_valid_o), 1);

    // R10: read during another repeat pass
    for (int k = 0; k < 8; k++) begin
      drive_nib(1'b0, prev[4*k +: 4], k == 3);
      if (k == 3) begin
        chk("R10 ack", 32'(rd_ack_o), 1);
        chk("R10 data", rd_data_o, prev);
      end
      if (k == 5) begin
        chk("R10 ack low", 32'(rd_ack_o), 0);
        chk("R10 data held", rd_data_o, prev);
      end
    end

    // R6: aborted message then a full one
    for (int k = 0; k < 3; k++) drive_nib(k == 0, 4'hD - 4'(k), 1'b0);
    chk("R6 old word kept", word_o, prev);
    chk("R6 valid low", 32'(word_valid_o), 0);
    for (int k = 0; k < 8; k++) drive_nib(k == 0, 32'h1357_9BDF >> (4*k), 1'b0);
    chk("R6 word", word_o, 32'h1357_9BDF);

    // R8: silent sender
    for (int k = 0; k < 8; k++) drive_nib(1'b0, 4'h0, 1'b0);
    chk("R8 word zero", word_o, 0);
    chk("R8 valid", 32'(word_valid_o), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule